// File: doc/BRIEF.md
# Inverter Overcurrent Shutdown Controller

This block is the digital end of an inverter's overcurrent protection. A fast comparator outside the block raises a fault flag when the sensed bus current crosses the fault threshold. That threshold is separate from, and higher than, the ordinary current limit that handles start-up inrush. The block brings the flag into its clock domain. The moment the synchronized flag is seen, it turns off gate drive to both the upper and the lower switch groups and latches that condition.

The latch releases by itself after a recycle time counted in millisecond timebase ticks (ten by default). If the fault is still present when that time runs out, the latch stays set and the count starts again. When faults keep coming back, the block escalates to a sticky high-voltage supply shutdown so that the inverter stops completely. Two things trigger escalation: several separate trips inside a sliding window opened by the first one, or a fault that stays asserted across many consecutive ticks. A two-bit status output reports the idle, latched and locked-out states.

Top module: `ocp_shutdown_ctrl`

## Requirements
- R1: The raw fault input passes through two flip-flops before it is used. A fault applied just after a clock edge leaves the gate shutdown outputs low after the next edge and raises them after the second edge.
- R2: `upper_off` and `lower_off` always carry the same value. They go high in the same cycle as the synchronized fault, before the state register has changed.
- R3: `status` reads 0 when idle, 1 when latched and 2 when locked out. An idle block that sees the synchronized fault reads 1 from the following cycle.
- R4: A latched block returns to idle on the RECYCLE_TICKS-th tick counted while latched, provided the synchronized fault is low at that edge. Both gate outputs drop with it.
- R5: If the synchronized fault is high at recycle expiry, the block stays latched and starts a new recycle count. Such a re-arm does not count as a new trip.
- R6: A trip is a move from idle to latched. The first trip opens a window. When the TRIP_LIMIT-th trip arrives before that window has run for WINDOW_TICKS ticks, the block goes directly to lock-out.
- R7: After WINDOW_TICKS ticks the window closes and the trip count is cleared, so the next trip counts as the first of a new window.
- R8: If the synchronized fault is high at PERSIST_TICKS consecutive ticks, the block locks out on the edge of the last of those ticks. Any cycle with the fault low clears that count.
- R9: In lock-out, `supply_off`, `upper_off` and `lower_off` are all high, and they stay high until reset whatever the fault input does.
- R10: Synchronous active-high reset returns the block to idle with every output low and all counters cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fault_raw | input | 1 | Asynchronous overcurrent flag from the comparator |
| tick | input | 1 | One-cycle timebase pulse, nominally every 1 ms |
| upper_off | output | 1 | Inhibit gate drive of the upper switch group |
| lower_off | output | 1 | Inhibit gate drive of the lower switch group |
| supply_off | output | 1 | Shut down the high-voltage supply (sticky) |
| status | output | 2 | 0 idle, 1 latched, 2 locked out |

## Verification
The hardest states to reach from the ports are the edges of the two escalation paths. The trip-count path needs several complete recycle periods inside one window. The persistence path needs a fault held through several back-to-back re-arms without being mistaken for new trips. The stimulus table drives the fault level for a whole number of tick periods and places every tick on the last cycle of its period. The count of ticks since any trip is therefore known exactly, and the bench can stage trips that land just inside the window, trips that fall after it has closed, and a persistence run that is broken off at thirty ticks and then restarted.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

    localparam int unsigned DEF_RECYCLE_TICKS = 10;
    localparam int unsigned DEF_WINDOW_TICKS  = 100;
    localparam int unsigned DEF_TRIP_LIMIT    = 4;
    localparam int unsigned DEF_PERSIST_TICKS = 50;
    localparam int unsigned DEF_SYNC_STAGES   = 2;

    typedef enum logic [1:0] {
        PS_IDLE    = 2'd0,
        PS_TRIPPED = 2'd1,
        PS_LOCKED  = 2'd2
    } prot_state_t;

    typedef struct packed {
        logic trip;     // idle to latched move this cycle
        logic expire;   // recycle time ran out this cycle
        logic escalate; // escalation requested this cycle
    } prot_evt_t;

    function automatic logic gates_inhibited(prot_state_t st, logic fault_s);
        return fault_s || (st != PS_IDLE);
    endfunction

endpackage

// File: rtl/ocp_sync.sv
module ocp_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[i] <= 1'b0;
                    else     chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/ocp_recycle_timer.sv
module ocp_recycle_timer #(
    parameter int unsigned RECYCLE_TICKS = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    output logic expire
);
    localparam int unsigned CW = $clog2(RECYCLE_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(RECYCLE_TICKS - 1);

    logic [CW-1:0] cnt_q;

    assign expire = run && tick && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= expire ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/ocp_escalation.sv
module ocp_escalation #(
    parameter int unsigned WINDOW_TICKS  = 100,
    parameter int unsigned TRIP_LIMIT    = 4,
    parameter int unsigned PERSIST_TICKS = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic fault_s,
    input  logic tick,
    input  logic trip,
    output logic escalate
);
    localparam int unsigned WW = $clog2(WINDOW_TICKS + 1);
    localparam int unsigned TW = $clog2(TRIP_LIMIT + 1);
    localparam int unsigned PW = $clog2(PERSIST_TICKS + 1);
    localparam logic [WW-1:0] W_LAST = WW'(WINDOW_TICKS - 1);
    localparam logic [TW-1:0] T_LIM  = TW'(TRIP_LIMIT);
    localparam logic [PW-1:0] P_LAST = PW'(PERSIST_TICKS - 1);
    localparam logic [PW-1:0] P_FULL = PW'(PERSIST_TICKS);

    // trip-rate window
    logic          win_open_q;
    logic [WW-1:0] win_cnt_q;
    logic [TW-1:0] trip_cnt_q;
    logic          closing;
    logic          eff_open;
    logic [TW-1:0] trips_after;
    logic          esc_trips;

    assign closing     = win_open_q && tick && (win_cnt_q == W_LAST);
    assign eff_open    = win_open_q && !closing;
    assign trips_after = eff_open ? ((trip_cnt_q < T_LIM) ? trip_cnt_q + 1'b1 : trip_cnt_q)
                                  : TW'(1);
    assign esc_trips   = trip && (trips_after >= T_LIM);

    always_ff @(posedge clk) begin
        if (rst) begin
            win_open_q <= 1'b0;
            win_cnt_q  <= '0;
            trip_cnt_q <= '0;
        end else if (trip) begin
            win_open_q <= 1'b1;
            trip_cnt_q <= trips_after;
            if (eff_open) win_cnt_q <= tick ? win_cnt_q + 1'b1 : win_cnt_q;
            else          win_cnt_q <= '0;
        end else if (closing) begin
            win_open_q <= 1'b0;
            win_cnt_q  <= '0;
            trip_cnt_q <= '0;
        end else if (win_open_q && tick) begin
            win_cnt_q <= win_cnt_q + 1'b1;
        end
    end

    // persistence of the synchronized fault
    logic [PW-1:0] pers_cnt_q;
    logic          esc_persist;

    assign esc_persist = fault_s && ((tick && (pers_cnt_q == P_LAST)) || (pers_cnt_q == P_FULL));

    always_ff @(posedge clk) begin
        if (rst || !fault_s) begin
            pers_cnt_q <= '0;
        end else if (tick && (pers_cnt_q != P_FULL)) begin
            pers_cnt_q <= pers_cnt_q + 1'b1;
        end
    end

    assign escalate = esc_trips || esc_persist;
endmodule

// File: rtl/ocp_latch_fsm.sv
module ocp_latch_fsm
    import ocp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        fault_s,
    input  logic        expire,
    input  logic        escalate,
    output logic        trip,
    output prot_state_t state
);
    prot_state_t state_q, state_d;
    prot_evt_t   evt;

    assign evt.trip     = (state_q == PS_IDLE) && fault_s;
    assign evt.expire   = expire;
    assign evt.escalate = escalate;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_IDLE: begin
                if (evt.trip) state_d = evt.escalate ? PS_LOCKED : PS_TRIPPED;
            end
            PS_TRIPPED: begin
                if (evt.escalate)    state_d = PS_LOCKED;
                else if (evt.expire) state_d = fault_s ? PS_TRIPPED : PS_IDLE;
            end
            PS_LOCKED: state_d = PS_LOCKED;
            default:   state_d = PS_LOCKED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= PS_IDLE;
        else     state_q <= state_d;
    end

    assign trip  = evt.trip;
    assign state = state_q;
endmodule

// File: rtl/ocp_shutdown_ctrl.sv
module ocp_shutdown_ctrl
    import ocp_pkg::*;
#(
    parameter int unsigned SYNC_STAGES   = DEF_SYNC_STAGES,
    parameter int unsigned RECYCLE_TICKS = DEF_RECYCLE_TICKS,
    parameter int unsigned WINDOW_TICKS  = DEF_WINDOW_TICKS,
    parameter int unsigned TRIP_LIMIT    = DEF_TRIP_LIMIT,
    parameter int unsigned PERSIST_TICKS = DEF_PERSIST_TICKS
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       fault_raw,
    input  logic       tick,
    output logic       upper_off,
    output logic       lower_off,
    output logic       supply_off,
    output logic [1:0] status
);
    logic        fault_s;
    logic        expire;
    logic        escalate;
    logic        trip;
    prot_state_t state;

    ocp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (fault_raw),
        .q_sync  (fault_s)
    );

    ocp_recycle_timer #(.RECYCLE_TICKS(RECYCLE_TICKS)) u_recycle (
        .clk    (clk),
        .rst    (rst),
        .run    (state == PS_TRIPPED),
        .tick   (tick),
        .expire (expire)
    );

    ocp_escalation #(
        .WINDOW_TICKS  (WINDOW_TICKS),
        .TRIP_LIMIT    (TRIP_LIMIT),
        .PERSIST_TICKS (PERSIST_TICKS)
    ) u_escalate (
        .clk      (clk),
        .rst      (rst),
        .fault_s  (fault_s),
        .tick     (tick),
        .trip     (trip),
        .escalate (escalate)
    );

    ocp_latch_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .fault_s  (fault_s),
        .expire   (expire),
        .escalate (escalate),
        .trip     (trip),
        .state    (state)
    );

    logic gate_inh;
    assign gate_inh   = gates_inhibited(state, fault_s);
    assign upper_off  = gate_inh;
    assign lower_off  = gate_inh;
    assign supply_off = (state == PS_LOCKED);
    assign status     = state;
endmodule

// File: rtl/ocp_shutdown_checker.sv
module ocp_shutdown_checker (
    input logic       clk,
    input logic       rst,
    input logic       fault_raw,
    input logic       tick,
    input logic       upper_off,
    input logic       lower_off,
    input logic       supply_off,
    input logic [1:0] status
);
    a_r2_gates_match: assert property (@(posedge clk) disable iff (rst)
        upper_off == lower_off);

    a_r1_sync_delay: assert property (@(posedge clk) disable iff (rst)
        (status == 2'd0 && upper_off) |-> $past(fault_raw, 2));

    a_r4_release_on_tick: assert property (@(posedge clk) disable iff (rst)
        (status == 2'd1 && !tick) |=> (status != 2'd0));

    a_r9_lock_sticky: assert property (@(posedge clk) disable iff (rst)
        (status == 2'd2) |=> (status == 2'd2 && supply_off));

    a_r9_supply_implies_gates: assert property (@(posedge clk) disable iff (rst)
        supply_off |-> (upper_off && lower_off));

    a_r3_valid_code: assert property (@(posedge clk) disable iff (rst)
        status != 2'd3);
endmodule

bind ocp_shutdown_ctrl ocp_shutdown_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .fault_raw  (fault_raw),
    .tick       (tick),
    .upper_off  (upper_off),
    .lower_off  (lower_off),
    .supply_off (supply_off),
    .status     (status)
);

// File: tb/test_ocp_shutdown_ctrl.sv
module test_ocp_shutdown_ctrl;
    localparam time CLK_PERIOD = 10ns;
    localparam int  TICK_CYC   = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fault_raw = 1'b0;
    logic       tick = 1'b0;
    logic       upper_off, lower_off, supply_off;
    logic [1:0] status;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ocp_shutdown_ctrl i_ocp_shutdown_ctrl (
        .clk        (clk),
        .rst        (rst),
        .fault_raw  (fault_raw),
        .tick       (tick),
        .upper_off  (upper_off),
        .lower_off  (lower_off),
        .supply_off (supply_off),
        .status     (status)
    );

    typedef struct packed {
        logic       rst_first;
        logic       flt;
        logic [7:0] nticks;
        logic       exp_gate;
        logic       exp_supply;
        logic [1:0] exp_status;
        logic [3:0] req;
    } vec_t;

    // status codes: 0 idle, 1 latched, 2 locked out
    localparam vec_t VECS [25] = '{
        // trip-count escalation: R3 R4 R5 R6 R9
        '{1'b1, 1'b1, 8'd1,  1'b1, 1'b0, 2'd1, 4'd3},
        '{1'b0, 1'b0, 8'd8,  1'b1, 1'b0, 2'd1, 4'd4},
        '{1'b0, 1'b0, 8'd1,  1'b0, 1'b0, 2'd0, 4'd4},
        '{1'b0, 1'b1, 8'd1,  1'b1, 1'b0, 2'd1, 4'd3},
        '{1'b0, 1'b1, 8'd9,  1'b1, 1'b0, 2'd1, 4'd5},
        '{1'b0, 1'b0, 8'd1,  1'b1, 1'b0, 2'd1, 4'd5},
        '{1'b0, 1'b0, 8'd9,  1'b0, 1'b0, 2'd0, 4'd4},
        '{1'b0, 1'b1, 8'd1,  1'b1, 1'b0, 2'd1, 4'd3},
        '{1'b0, 1'b0, 8'd9,  1'b0, 1'b0, 2'd0, 4'd4},
        '{1'b0, 1'b1, 8'd1,  1'b1, 1'b1, 2'd2, 4'd6},
        '{1'b0, 1'b0, 8'd5,  1'b1, 1'b1, 2'd2, 4'd9},
        // window expiry: R7
        '{1'b1, 1'b1, 8'd1,  1'b1, 1'b0, 2'd1, 4'd3},
        '{1'b0, 1'b0, 8'd9,  1'b0, 1'b0, 2'd0, 4'd4},
        '{1'b0, 1'b1, 8'd1,  1'b1, 1'b0, 2'd1, 4'd3},
        '{1'b0, 1'b0, 8'd9,  1'b0, 1'b0, 2'd0, 4'd4},
        '{1'b0, 1'b1, 8'd1,  1'b1, 1'b0, 2'd1, 4'd3},
        '{1'b0, 1'b0, 8'd9,  1'b0, 1'b0, 2'd0, 4'd4},
        '{1'b0, 1'b0, 8'd75, 1'b0, 1'b0, 2'd0, 4'd7},
        '{1'b0, 1'b1, 8'd1,  1'b1, 1'b0, 2'd1, 4'd7},
        // persistence: R8
        '{1'b1, 1'b1, 8'd49, 1'b1, 1'b0, 2'd1, 4'd8},
        '{1'b0, 1'b1, 8'd1,  1'b1, 1'b1, 2'd2, 4'd8},
        // persistence cleared by a gap: R8
        '{1'b1, 1'b1, 8'd30, 1'b1, 1'b0, 2'd1, 4'd5},
        '{1'b0, 1'b0, 8'd1,  1'b1, 1'b0, 2'd1, 4'd4},
        '{1'b0, 1'b0, 8'd9,  1'b0, 1'b0, 2'd0, 4'd4},
        '{1'b0, 1'b1, 8'd30, 1'b1, 1'b0, 2'd1, 4'd8}
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(input logic t);
        tick = t;
        @(posedge clk);
        #1;
        tick = 1'b0;
    endtask

    task automatic run_ticks(input int n, input logic f);
        fault_raw = f;
        for (int k = 0; k < n; k++) begin
            repeat (TICK_CYC - 1) cyc(1'b0);
            cyc(1'b1);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        fault_raw = 1'b0;
        cyc(1'b0);
        cyc(1'b0);
        rst = 1'b0;
    endtask

    initial begin
        do_reset();
        // R10: reset state
        check("R10", "upper_off", upper_off, 0);
        check("R10", "lower_off", lower_off, 0);
        check("R10", "supply_off", supply_off, 0);
        check("R10", "status", status, 0);

        for (int i = 0; i < 25; i++) begin
            string rq;
            rq = $sformatf("R%0d", VECS[i].req);
            if (VECS[i].rst_first) do_reset();
            run_ticks(VECS[i].nticks, VECS[i].flt);
            check(rq, "upper_off", upper_off, VECS[i].exp_gate);
            check(rq, "lower_off", lower_off, VECS[i].exp_gate);
            check(rq, "supply_off", supply_off, VECS[i].exp_supply);
            check(rq, "status", status, VECS[i].exp_status);
        end

        // R1 R2 R3: synchronizer latency and immediate inhibit
        do_reset();
        fault_raw = 1'b1;
        cyc(1'b0);
        check("R1", "upper_off after one edge", upper_off, 0);
        cyc(1'b0);
        check("R2", "upper_off after two edges", upper_off, 1);
        check("R2", "lower_off after two edges", lower_off, 1);
        check("R2", "status while inhibited", status, 0);
        cyc(1'b0);
        check("R3", "status latched", status, 1);

        // R9 R10: lock-out holds against fault removal, cleared only by reset
        do_reset();
        run_ticks(50, 1'b1);
        check("R9", "supply_off persist", supply_off, 1);
        run_ticks(3, 1'b0);
        check("R9", "supply_off held", supply_off, 1);
        check("R9", "upper_off held", upper_off, 1);
        do_reset();
        check("R10", "supply_off after reset", supply_off, 0);
        check("R10", "status after reset", status, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule